// File: doc/BRIEF.md
# Transfer Data FIFO with Request and Event Flags

This block sits between a host data port and a serial shift engine. It holds up to 64 words of 32 bits in first-in, first-out order. The oldest word is always shown on the read port ahead of a pop. Either side can push or pop. A flush input empties the store at once.

Around the store, five sticky event flags record what has happened. A receive request means the store has filled to a programmable level. A transmit request means enough free room is left. Overflow marks a push that found the store full, and underflow marks a pop that found it empty. An end flag marks a finished transaction. The flags sit in the low bits of a status word, and the live fill count sits in bits 22:16 of the same word. Software-side logic clears flags with a write-one-to-clear strobe. An interrupt mask with the same bit layout gates the flags onto one interrupt line.

Top module: `xfer_data_fifo`

## Requirements
- R1: While reset is held and right after it, the status word reads 0, the mask register holds all ones and `irq` is 0.
- R2: Words leave in the order they were accepted. `pop_data` shows the oldest stored word whenever the count is nonzero. `status[22:16]` holds the fill count, which rises by one per accepted push, falls by one per accepted pop, and does not change on a cycle with both.
- R3: A push while the count is 64 is dropped: the count and the stored words stay unchanged, and overflow flag `status[1]` is set on that clock edge.
- R4: A pop while the count is 0 is dropped: the count stays at 0, and underflow flag `status[0]` is set on that clock edge.
- R5: Receive request flag `status[2]` is set on the edge after a cycle in which the registered count is at or above `thresh`. With `thresh` 0 it sets even when the store is empty.
- R6: Transmit request flag `status[3]` is set on the edge after a cycle in which 64 minus the registered count is at or above `thresh`.
- R7: A one-cycle pulse on `xfer_end` sets end flag `status[4]` on that clock edge.
- R8: All five flags are sticky. A flag falls only on a `clr_we` cycle whose `clr_bits` has a 1 at that flag's position; 0x1F clears every flag. A set condition present on the same edge wins over the clear.
- R9: A `msk_we` cycle loads `msk_bits` into the mask register. A mask bit of 1 blocks the flag at the same position. `irq` is 1 exactly when some flag is set and its mask bit is 0.
- R10: `flush` sets the count to 0 on that edge. It overrides a push or pop in the same cycle, and that push or pop stores nothing and raises no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the store this cycle |
| thresh | input | 6 | Request level for both request flags |
| push_valid | input | 1 | Push `push_data` this cycle |
| push_data | input | 32 | Word to store |
| pop_req | input | 1 | Remove the oldest word this cycle |
| pop_data | output | 32 | Oldest stored word (show-ahead) |
| xfer_end | input | 1 | Transaction finished pulse |
| clr_we | input | 1 | Apply write-one-to-clear |
| clr_bits | input | 5 | Flags to clear (1 clears) |
| msk_we | input | 1 | Load the interrupt mask |
| msk_bits | input | 5 | New mask value (1 masks) |
| status | output | 32 | Fill count in bits 22:16, flags in bits 4:0, other bits 0 |
| irq | output | 1 | OR of unmasked flags |

## Verification
On every cycle, the assertions check several things. The count never exceeds the depth. A rejected push or pop leaves the count alone, and a flush empties the store. A flag never drops without a matching clear bit, and a clear without a competing set does take effect. A finished transaction and a reached receive level always leave their flag raised, and a fully masked set of flags keeps the interrupt low. Only the bench scenarios can show the word order across a pointer wrap, that a dropped word is truly absent, and the exact threshold edges for both requests. They also show that a clear loses to a persisting condition and that a flush beats a simultaneous push.

// File: rtl/xfq_pkg.sv
package xfq_pkg;
   localparam int FLG_N      = 5;
   localparam int FLG_UNDER  = 0;
   localparam int FLG_OVER   = 1;
   localparam int FLG_RXREQ  = 2;
   localparam int FLG_TXREQ  = 3;
   localparam int FLG_END    = 4;
   localparam int ST_CNT_LSB = 16;
   localparam int ST_CNT_W   = 7;
   localparam int ST_W       = 32;
endpackage

// File: rtl/xfq_store.sv
module xfq_store #(
   parameter int DW    = 32,
   parameter int DEPTH = 64,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push_req,
   input  logic [DW-1:0] push_data,
   input  logic          pop_req,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] level,
   output logic          push_drop,
   output logic          pop_drop
);
   localparam int  AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit  IS_P2  = ((DEPTH & (DEPTH - 1)) == 0);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_inc, rd_inc;
   logic          full, empty, push_ok, pop_ok;

   assign full      = (level == CW'(DEPTH));
   assign empty     = (level == '0);
   assign push_ok   = push_req && !flush && !full;
   assign pop_ok    = pop_req  && !flush && !empty;
   assign push_drop = push_req && !flush && full;
   assign pop_drop  = pop_req  && !flush && empty;

   generate
      if (IS_P2) begin : g_wrap_nat
         assign wr_inc = wr_ptr + 1'b1;
         assign rd_inc = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_inc = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_inc = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_inc;
         if (pop_ok)  rd_ptr <= rd_inc;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   assign rd_data = mem[rd_ptr];

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH)); // R2
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push_req && !pop_req && !flush) |=> (level == CW'(DEPTH))); // R3
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop_req && !push_req && !flush) |=> (level == '0)); // R4
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level == '0)); // R10
endmodule

// File: rtl/xfq_events.sv
module xfq_events #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic         clr_we,
   input  logic [N-1:0] clr_bits,
   input  logic         msk_we,
   input  logic [N-1:0] msk_bits,
   output logic [N-1:0] flags,
   output logic [N-1:0] mask_q,
   output logic         irq
);
   logic [N-1:0] clr_eff;

   assign clr_eff = clr_we ? clr_bits : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags  <= '0;
         mask_q <= '1;
      end else begin
         flags <= (flags & ~clr_eff) | set_vec;
         if (msk_we) mask_q <= msk_bits;
      end
   end

   assign irq = |(flags & ~mask_q);

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((~flags & $past(flags) & ~($past(clr_we) ? $past(clr_bits) : '0)) == '0)); // R8
   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((flags & $past(clr_bits & ~set_vec)) == '0)); // R8
endmodule

// File: rtl/xfer_data_fifo.sv
module xfer_data_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 64,
   parameter int TW    = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      flush,
   input  logic [TW-1:0]             thresh,
   input  logic                      push_valid,
   input  logic [DW-1:0]             push_data,
   input  logic                      pop_req,
   output logic [DW-1:0]             pop_data,
   input  logic                      xfer_end,
   input  logic                      clr_we,
   input  logic [xfq_pkg::FLG_N-1:0] clr_bits,
   input  logic                      msk_we,
   input  logic [xfq_pkg::FLG_N-1:0] msk_bits,
   output logic [xfq_pkg::ST_W-1:0]  status,
   output logic                      irq
);
   import xfq_pkg::*;

   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_chk_depth
      $error("xfer_data_fifo: DEPTH must be at least 2");
   end
   if (CW > ST_CNT_W) begin : g_chk_cnt
      $error("xfer_data_fifo: fill count does not fit the status field");
   end
   if (TW > CW) begin : g_chk_thr
      $error("xfer_data_fifo: threshold wider than the fill count");
   end

   logic [CW-1:0]    level, free_sp, thr_ext;
   logic             push_drop, pop_drop;
   logic [FLG_N-1:0] set_vec, flags, mask_q;

   xfq_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push_req  (push_valid),
      .push_data (push_data),
      .pop_req   (pop_req),
      .rd_data   (pop_data),
      .level     (level),
      .push_drop (push_drop),
      .pop_drop  (pop_drop)
   );

   assign thr_ext = CW'(thresh);
   assign free_sp = CW'(DEPTH) - level;

   always_comb begin
      set_vec            = '0;
      set_vec[FLG_UNDER] = pop_drop;
      set_vec[FLG_OVER]  = push_drop;
      set_vec[FLG_RXREQ] = (level >= thr_ext);
      set_vec[FLG_TXREQ] = (free_sp >= thr_ext);
      set_vec[FLG_END]   = xfer_end;
   end

   xfq_events #(.N(FLG_N)) u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .clr_we   (clr_we),
      .clr_bits (clr_bits),
      .msk_we   (msk_we),
      .msk_bits (msk_bits),
      .flags    (flags),
      .mask_q   (mask_q),
      .irq      (irq)
   );

   always_comb begin
      status                     = '0;
      status[ST_CNT_LSB +: CW]   = level;
      status[FLG_N-1:0]          = flags;
   end

   AST_END_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end |=> status[FLG_END]); // R7
   AST_RXREQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (level >= thr_ext) |=> status[FLG_RXREQ]); // R5
   AST_IRQ_ALLMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '1) |-> !irq); // R9
endmodule

// File: tb/xfer_data_fifo_tb.sv
`timescale 1ns/1ps
module xfer_data_fifo_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        flush;
   logic [5:0]  thresh;
   logic        push_valid;
   logic [31:0] push_data;
   logic        pop_req;
   logic [31:0] pop_data;
   logic        xfer_end;
   logic        clr_we;
   logic [4:0]  clr_bits;
   logic        msk_we;
   logic [4:0]  msk_bits;
   logic [31:0] status;
   logic        irq;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   xfer_data_fifo dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .thresh(thresh),
      .push_valid(push_valid), .push_data(push_data), .pop_req(pop_req),
      .pop_data(pop_data), .xfer_end(xfer_end), .clr_we(clr_we),
      .clr_bits(clr_bits), .msk_we(msk_we), .msk_bits(msk_bits),
      .status(status), .irq(irq)
   );

   // op(3) arg(32) cnt(7) flags(5) irq(1) head(32); ops: 0 idle 1 push 2 pop 3 clear 4 end 5 mask
   localparam int NV = 14;
   localparam logic [79:0] TBL [NV] = '{
      {3'd2, 32'h0000_0000, 7'd0, 5'h09, 1'b0, 32'h0},          // R4
      {3'd3, 32'h0000_0001, 7'd0, 5'h08, 1'b0, 32'h0},          // R8
      {3'd1, 32'hA1A1_0001, 7'd1, 5'h08, 1'b0, 32'hA1A1_0001},  // R2
      {3'd1, 32'hA1A1_0002, 7'd2, 5'h08, 1'b0, 32'hA1A1_0001},  // R2
      {3'd1, 32'hA1A1_0003, 7'd3, 5'h0C, 1'b0, 32'hA1A1_0001},  // R5
      {3'd3, 32'h0000_0004, 7'd3, 5'h0C, 1'b0, 32'hA1A1_0001},  // R8
      {3'd2, 32'h0000_0000, 7'd2, 5'h0C, 1'b0, 32'hA1A1_0002},  // R2
      {3'd3, 32'h0000_0004, 7'd2, 5'h08, 1'b0, 32'hA1A1_0002},  // R8
      {3'd4, 32'h0000_0000, 7'd2, 5'h18, 1'b0, 32'hA1A1_0002},  // R7
      {3'd3, 32'h0000_001F, 7'd2, 5'h08, 1'b0, 32'hA1A1_0002},  // R8
      {3'd5, 32'h0000_0017, 7'd2, 5'h08, 1'b1, 32'hA1A1_0002},  // R9
      {3'd5, 32'h0000_001F, 7'd2, 5'h08, 1'b0, 32'hA1A1_0002},  // R9
      {3'd5, 32'h0000_001E, 7'd2, 5'h08, 1'b0, 32'hA1A1_0002},  // R9
      {3'd2, 32'h0000_0000, 7'd1, 5'h08, 1'b0, 32'hA1A1_0003}   // R2
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      flush = 0; push_valid = 0; pop_req = 0; xfer_end = 0;
      clr_we = 0; msk_we = 0;
   endtask

   task automatic apply_op(input logic [2:0] op, input logic [31:0] arg);
      case (op)
         3'd1: begin push_valid = 1; push_data = arg; end
         3'd2: pop_req = 1;
         3'd3: begin clr_we = 1; clr_bits = arg[4:0]; end
         3'd4: xfer_end = 1;
         3'd5: begin msk_we = 1; msk_bits = arg[4:0]; end
         default: ;
      endcase
      @(negedge clk);
      idle_inputs();
      @(negedge clk);
   endtask

   task automatic clear_all();
      clr_we = 1; clr_bits = 5'h1F;
      @(negedge clk);
      clr_we = 0;
      @(negedge clk);
   endtask

   initial begin
      rst_n = 0; thresh = 6'd3; push_data = '0; clr_bits = '0; msk_bits = '0;
      idle_inputs();
      repeat (3) @(negedge clk);
      chk("R1 status in reset", status, 32'h0);
      chk("R1 irq in reset", {31'b0, irq}, 32'h0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 count after reset", {25'b0, status[22:16]}, 32'h0);
      @(negedge clk);
      chk("R1 irq masked after reset", {31'b0, irq}, 32'h0);
      chk("R6 txreq after reset", {27'b0, status[4:0]}, 32'h08);

      for (int v = 0; v < NV; v++) begin
         apply_op(TBL[v][79:77], TBL[v][76:45]);
         chk($sformatf("R2 count step %0d", v), {25'b0, status[22:16]}, {25'b0, TBL[v][44:38]});
         chk($sformatf("R8 flags step %0d", v), {27'b0, status[4:0]}, {27'b0, TBL[v][37:33]});
         chk($sformatf("R9 irq step %0d", v), {31'b0, irq}, {31'b0, TBL[v][32]});
         if (TBL[v][44:38] != 0)
            chk($sformatf("R2 head step %0d", v), pop_data, TBL[v][31:0]);
      end

      // overflow with wrap, thresholds at 63
      thresh = 6'd63;
      msk_we = 1; msk_bits = 5'h1F; flush = 1;
      @(negedge clk);
      idle_inputs();
      clear_all();
      for (int i = 0; i < 65; i++) begin
         push_valid = 1; push_data = 32'h5A00_0000 + i;
         @(negedge clk);
      end
      push_valid = 0;
      chk("R3 count held at full", {25'b0, status[22:16]}, 32'd64);
      chk("R3 overflow flag", {31'b0, status[1]}, 32'h1);
      clear_all();
      chk("R5 R6 flags at full, thresh 63", {27'b0, status[4:0]}, 32'h04);
      for (int i = 0; i < 62; i++) begin
         chk("R2 order after wrap", pop_data, 32'h5A00_0000 + i);
         pop_req = 1;
         @(negedge clk);
      end
      pop_req = 0;
      clear_all();
      chk("R6 no txreq with 62 free", {27'b0, status[4:0]}, 32'h00);
      chk("R2 head before pop 62", pop_data, 32'h5A00_003E);
      pop_req = 1;
      @(negedge clk);
      pop_req = 0;
      @(negedge clk);
      chk("R6 txreq with 63 free", {27'b0, status[4:0]}, 32'h08);
      chk("R3 last stored word", pop_data, 32'h5A00_003F);
      pop_req = 1;
      @(negedge clk);
      @(negedge clk);
      pop_req = 0;
      chk("R4 underflow after drain", {27'b0, status[4:0]}, 32'h09);
      chk("R4 count stays zero", {25'b0, status[22:16]}, 32'h0);

      // flush beats push
      clear_all();
      for (int i = 0; i < 3; i++) begin
         push_valid = 1; push_data = 32'hC0DE_0000 + i;
         @(negedge clk);
      end
      flush = 1; push_data = 32'hFFFF_FFFF;
      @(negedge clk);
      idle_inputs();
      chk("R10 flush empties", {25'b0, status[22:16]}, 32'h0);
      chk("R10 no over/under on flush", {30'b0, status[1:0]}, 32'h0);
      push_valid = 1; push_data = 32'h1234_5678;
      @(negedge clk);
      push_valid = 0;
      chk("R10 fresh head after flush", pop_data, 32'h1234_5678);

      // simultaneous push and pop
      push_valid = 1; push_data = 32'h9ABC_0000; pop_req = 1;
      @(negedge clk);
      idle_inputs();
      chk("R2 count unchanged on push+pop", {25'b0, status[22:16]}, 32'd1);
      chk("R2 head after push+pop", pop_data, 32'h9ABC_0000);

      // threshold zero with empty store
      pop_req = 1;
      @(negedge clk);
      idle_inputs();
      thresh = 6'd0;
      clear_all();
      chk("R5 rxreq with thresh 0 when empty", {31'b0, status[2]}, 32'h1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule